// File: doc/BRIEF.md
# Eight-Bit Microcoded Datapath ALU

This is the arithmetic and logic unit of an eight-bit datapath that a microprogram controls. It is purely combinational. Each microinstruction supplies two operands from the register-select multiplexers, a three-bit operation code and a separate carry-in bit. The unit returns an eight-bit result, a carry-out flag and a sign flag, which is a copy of the top result bit.

All arithmetic runs through one adder. Its second input is chosen by the operation: B, the complement of B, all zeros or all ones. The explicit carry-in then turns that one adder into several functions. With it the microcode gets increment (pass-A with carry set), decrement with a nonzero test (A minus one, where carry-out reports that A was nonzero), subtraction (A plus the complement of B with carry set), and left shift (A added to itself, with carry-in shifting a one into bit 0). The microcode clears a register by subtracting it from itself. It passes a register through by ANDing it with itself.

Top module: `dp_alu`

## Requirements
- R1: Operation code 0 (AND) gives the bitwise AND of A and B.
- R2: Operation code 1 (OR) gives the bitwise OR of A and B.
- R3: Operation code 2 (ADD) gives the low eight bits of A+B+carry_in on result, and bit 8 of that sum on carry_out. With A equal to B this is a left shift: carry_out is the old bit 7, and carry_in fills bit 0.
- R4: Operation code 3 (SUB) computes A + (bitwise NOT B) + carry_in. Result and carry_out are bits 7..0 and bit 8 of that sum. With carry_in 1 the result is A-B, and carry_out is 1 exactly when A >= B.
- R5: Operation code 4 (ADDA) gives A+carry_in. Carry_out is 1 only when A is 0xFF and carry_in is 1.
- R6: Operation code 5 (SUBA) computes A + 0xFF + carry_in. With carry_in 0 the result is A-1, and carry_out is 1 exactly when A was nonzero. With carry_in 1 the result is A, and carry_out is 1.
- R7: Operation codes 6 and 7 give a result of 0 and a carry_out of 0, for any operands and any carry_in.
- R8: sign_out always equals bit 7 of result.
- R9: For the logic operations (codes 0 and 1), carry_out is 0 and carry_in has no effect on result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| op_code | input | 3 | Operation select (0 AND, 1 OR, 2 ADD, 3 SUB, 4 ADDA, 5 SUBA) |
| carry_in | input | 1 | Carry into bit 0 of the adder |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Adder bit 8 for arithmetic codes, 0 otherwise |
| sign_out | output | 1 | Copy of result bit 7 |

## Verification
The unit holds no state, so a fault in the operand selector, the carry chain or the output multiplexer appears at the ports as soon as the inputs settle, in the same cycle. A broken carry link corrupts only the operand pairs whose carry passes through that bit position. For this reason every operand pair is swept across the binary operations, and each unary operation is swept over all values of A with both carry-in values. A wrong operand-selector choice shows up as a result that is off by B or by one, and also as an inverted carry flag on the zero and nonzero boundaries of SUBA.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_ADDA = 3'd4,
    OP_SUBA = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  // what the adder sees on its second input
  typedef enum logic [1:0] {
    BSRC_PASS  = 2'd0,
    BSRC_INV   = 2'd1,
    BSRC_ZERO  = 2'd2,
    BSRC_ONES  = 2'd3
  } bsrc_e;

  function automatic bsrc_e bsrc_of(alu_op_e op);
    case (op)
      OP_ADD:  return BSRC_PASS;
      OP_SUB:  return BSRC_INV;
      OP_SUBA: return BSRC_ONES;
      default: return BSRC_ZERO;
    endcase
  endfunction

  function automatic logic is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDA) || (op == OP_SUBA);
  endfunction

  function automatic logic is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR);
  endfunction

endpackage

// File: rtl/dp_alu_bsel.sv
module dp_alu_bsel
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  bsrc_e          src,
  input  logic [W-1:0]   b_in,
  output logic [W-1:0]   b_eff
);
  always_comb begin
    case (src)
      BSRC_PASS: b_eff = b_in;
      BSRC_INV:  b_eff = ~b_in;
      BSRC_ONES: b_eff = '1;
      default:   b_eff = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic prop;
    assign prop          = x[gi] ^ y[gi];
    assign sum[gi]       = prop ^ chain[gi];
    assign chain[gi+1]   = (x[gi] & y[gi]) | (prop & chain[gi]);
  end

  assign cout = chain[W];
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         pick_or,
  output logic [W-1:0] z
);
  assign z = pick_or ? (x | y) : (x & y);
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   op_code,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         sign_out
);
  localparam int unsigned MSB = W - 1;

  alu_op_e      op_w;
  bsrc_e        bsrc_w;
  logic [W-1:0] b_eff_w;
  logic [W-1:0] add_sum_w;
  logic         add_cout_w;
  logic [W-1:0] logic_out_w;
  logic         arith_sel_w;
  logic         logic_sel_w;

  assign op_w        = alu_op_e'(op_code);
  assign bsrc_w      = bsrc_of(op_w);
  assign arith_sel_w = is_arith(op_w);
  assign logic_sel_w = is_logic(op_w);

  dp_alu_bsel #(.W(W)) u_bsel (
    .src   (bsrc_w),
    .b_in  (opnd_b),
    .b_eff (b_eff_w)
  );

  dp_alu_adder #(.W(W)) u_adder (
    .x    (opnd_a),
    .y    (b_eff_w),
    .cin  (carry_in),
    .sum  (add_sum_w),
    .cout (add_cout_w)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .x       (opnd_a),
    .y       (opnd_b),
    .pick_or (op_code[0]),
    .z       (logic_out_w)
  );

  always_comb begin
    if (arith_sel_w)      result = add_sum_w;
    else if (logic_sel_w) result = logic_out_w;
    else                  result = '0;
  end

  assign carry_out = arith_sel_w & add_cout_w;
  assign sign_out  = result[MSB];
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [2:0]   op_code,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         sign_out,
  input logic [W-1:0] b_eff_w
);
  localparam int unsigned XW = W + 2;
  logic [XW-1:0] wide_res, wide_a, wide_b, wide_c, ones_w;

  always_comb begin
    wide_res = XW'({carry_out, result});
    wide_a   = XW'(opnd_a);
    wide_b   = XW'(opnd_b);
    wide_c   = XW'(carry_in);
    ones_w   = XW'({W{1'b1}});
    if (!$isunknown({opnd_a, opnd_b, op_code, carry_in, result, carry_out, sign_out})) begin
      if (op_code == 3'd0)
        assert_and_bits_R1: assert (((result ^ opnd_a) & opnd_b) == '0 && (result & ~opnd_b) == '0);
      if (op_code == 3'd1)
        assert_or_bits_R2: assert (((result ^ opnd_a) & ~opnd_b) == '0 && (result & opnd_b) == opnd_b);
      if (op_code == 3'd2)
        assert_add_sum_R3: assert ((wide_res - wide_a - wide_b) == wide_c);
      if (op_code == 3'd3)
        assert_sub_sum_R4: assert ((wide_res + wide_b) == (wide_a + ones_w + wide_c));
      if (op_code == 3'd4)
        assert_adda_R5: assert (wide_res - wide_a == wide_c);
      if (op_code == 3'd5 && !carry_in)
        assert_suba_nonzero_R6: assert (carry_out == (opnd_a != '0) && result + 1'b1 == opnd_a);
      if (op_code[2:1] == 2'b11)
        assert_reserved_zero_R7: assert (result == '0 && !carry_out);
      if (op_code[2:1] == 2'b00)
        assert_logic_no_carry_R9: assert (!carry_out);
      if (op_code == 3'd3)
        assert_sub_operand_R4: assert (b_eff_w == ~opnd_b);
    end
  end
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_code   (op_code),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out),
  .sign_out  (sign_out),
  .b_eff_w   (b_eff_w)
);

// File: tb/test_dp_alu.sv
`timescale 1ns/1ps
module test_dp_alu;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [2:0] op;
  logic       cin;
  logic [7:0] res;
  logic       co, sg;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #2.5 clk = ~clk;

  dp_alu i_dp_alu (
    .opnd_a(a), .opnd_b(b), .op_code(op), .carry_in(cin),
    .result(res), .carry_out(co), .sign_out(sg)
  );

  function automatic string req_of(int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input int va, input int vb, input int vo, input int vc);
    int s, er, ec;
    a = 8'(va); b = 8'(vb); op = 3'(vo); cin = 1'(vc);
    #1;
    case (vo)
      0: begin s = va & vb; end
      1: begin s = va | vb; end
      2: begin s = va + vb + vc; end
      3: begin s = va + (255 - vb) + vc; end
      4: begin s = va + vc; end
      5: begin s = va + 255 + vc; end
      default: s = 0;
    endcase
    er = s % 256;
    ec = (s / 256) % 2;
    n_vec++;
    if (res !== 8'(er) || co !== 1'(ec) || sg !== 1'(er / 128)) begin
      n_bad++;
      $display("FAIL %s%s op=%0d a=%0d b=%0d cin=%0d got res=%0d co=%0d sg=%0d exp res=%0d co=%0d sg=%0d",
               req_of(vo), (vo < 2) ? "/R9" : "/R8", vo, va, vb, vc, res, co, sg, er, ec, er / 128);
    end
    #1;
  endtask

  initial begin
    // power-up vector: AND of zeros (R1, R8)
    apply(0, 0, 0, 0);
    // R6 boundaries: SUBA of zero and one
    apply(0, 0, 5, 0);
    apply(1, 0, 5, 0);
    // R3 left shift of 0x80 with a one shifted in
    apply(128, 128, 2, 1);
    // R4 self-subtract clears
    apply(77, 77, 3, 1);
    // R7 reserved codes with carry set
    apply(255, 255, 6, 1);
    apply(255, 255, 7, 1);
    // R9 logic ops ignore carry_in
    apply(170, 85, 1, 1);
    apply(255, 15, 0, 1);
    // unary sweeps: R5 and R6 over all A, both carries
    for (int ua = 0; ua < 256; ua++)
      for (int uc = 0; uc < 2; uc++) begin
        apply(ua, ua ^ 8'h5a, 4, uc);
        apply(ua, ua ^ 8'ha5, 5, uc);
      end
    // full operand-pair sweeps rotating through all codes (R1..R4, R7, R8, R9)
    for (int pa = 0; pa < 256; pa++)
      for (int pb = 0; pb < 256; pb++) begin
        apply(pa, pb, (pa + pb) % 8, (pa ^ (pb >> 1)) & 1);
        apply(pa, pb, (pa + pb + 3) % 8, 1 - ((pa ^ (pb >> 1)) & 1));
      end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule